// File: doc/BRIEF.md
# Selectable-Rate Countdown Interrupt Timer

This block is a 12-bit down-counter that a CPU programs through two byte-wide write registers, one holding the upper four bits of the count and one holding the lower eight. Writing the low byte starts the count from the full 12-bit value made of both registers. Each strobe from the selected timebase takes one off the count. A select input picks the timebase: a fast strobe with a period well under a microsecond, or a slow strobe at video line rate.

When the count reaches zero, the counter reloads the last programmed value and keeps running. If the timer source is enabled in the interrupt enable register, a pending flag is also set, and that flag drives the interrupt request. A read of the status register returns the pending flag and clears it. A programmed value of zero leaves the timer stopped, and it then raises no interrupts.

The tick strobes come from outside the block. The block has no interrupt controller beyond the single enable bit.

Top module: `dtmr_top`

## Requirements
- R1: After reset, `irq` is low, a status read returns 0x00 and the timer is stopped, so no tick raises an interrupt until a count is started.
- R2: A write to address 0x94 stores `bus_wdata[3:0]` as the upper four count bits and ignores `bus_wdata[7:4]`. This write does not disturb a count already in progress. The new upper bits take effect at the next start or reload.
- R3: A write to address 0x95 stores the low byte. On the following clock edge the count becomes {upper nibble, low byte} and starts running.
- R4: With `rate_fast` = 1 only `fast_tick` advances the count. With `rate_fast` = 0 only `slow_tick` does. The other strobe has no effect.
- R5: Each selected tick while the count is non-zero lowers it by exactly one, so a programmed value N expires on the Nth tick and not before.
- R6: When a tick takes the count to zero, it reloads the programmed value in the same edge and keeps running, so the next expiry comes N ticks later.
- R7: Bit 5 of a write to address 0x92 is the timer interrupt enable. An expiry with the enable set makes `irq` high from the next edge. An expiry with the enable clear sets nothing.
- R8: A programmed value of zero leaves the timer stopped: no tick at either rate changes anything and `irq` stays low.
- R9: A read at address 0x92 returns the pending flag on `bus_rdata[5]`, with all other bits 0, in the same cycle. The flag is cleared at that edge, so `irq` is low afterwards.
- R10: If a status read and an expiry (with the enable set) fall in the same cycle, the new expiry wins and `irq` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; status at offset 0x92, zero otherwise |
| fast_tick | input | 1 | Sub-microsecond timebase strobe, one cycle per tick |
| slow_tick | input | 1 | Line-rate timebase strobe, one cycle per tick |
| rate_fast | input | 1 | Timebase select: 1 fast, 0 slow |
| irq | output | 1 | Interrupt request, high while the timer flag is pending |

## Verification
The bench counts ticks exactly to the expiry edge, one short and then on the spot. An off-by-one in the decrement or in the zero test would fire a tick early or late. The second period after an expiry tests the reload: a design that stopped or wrapped to 4095 would never fire again. Writing the upper byte in the middle of a count catches a design that restarts on that write. A zero program at both rates catches a counter that wraps through 0xFFF. A status read in the same cycle as an expiry catches a clear that drops a fresh event.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
    localparam int CNT_W  = 12;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 8;
    localparam int HI_W   = CNT_W - DATA_W;
    localparam int EN_BIT = 5;

    typedef struct packed {
        logic [HI_W-1:0]   hi;
        logic [DATA_W-1:0] lo;
        logic              ien;
    } regs_t;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             flag;
    } core_t;
endpackage

// File: rtl/dtmr_regfile.sv
module dtmr_regfile
    import dtmr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] A_HI   = 8'h94,
    parameter logic [ADDR_W-1:0] A_LO   = 8'h95,
    parameter logic [ADDR_W-1:0] A_STAT = 8'h92
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              flag,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  load_val,
    output logic              start,
    output logic              clr,
    output logic              ien
);
    regs_t r_d, r_q;
    logic  unused_wbits;

    assign unused_wbits = ^wdata;

    always_comb begin
        r_d = r_q;
        if (we && addr == A_HI)   r_d.hi  = wdata[HI_W-1:0];
        if (we && addr == A_LO)   r_d.lo  = wdata;
        if (we && addr == A_STAT) r_d.ien = wdata[EN_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        if (re && addr == A_STAT) rdata[EN_BIT] = flag;
    end

    // the start value already includes a low byte written in this cycle
    assign load_val = (we && addr == A_LO) ? {r_q.hi, wdata} : {r_q.hi, r_q.lo};
    assign start    = we && addr == A_LO;
    assign clr      = re && addr == A_STAT;
    assign ien      = r_q.ien;
endmodule

// File: rtl/dtmr_tick_sel.sv
module dtmr_tick_sel (
    input  logic fast_tick,
    input  logic slow_tick,
    input  logic rate_fast,
    output logic tick
);
    always_comb begin
        tick = rate_fast ? fast_tick : slow_tick;
    end
endmodule

// File: rtl/dtmr_core.sv
module dtmr_core
    import dtmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic [CNT_W-1:0] load_val,
    input  logic             ien,
    input  logic             clr,
    output logic [CNT_W-1:0] count,
    output logic             flag
);
    core_t c_d, c_q;
    logic  expire;

    always_comb begin
        c_d    = c_q;
        expire = tick && !start && (c_q.count == CNT_W'(1));
        if (start) begin
            c_d.count = load_val;
        end else if (tick && c_q.count != '0) begin
            if (expire) c_d.count = load_val;
            else        c_d.count = c_q.count - CNT_W'(1);
        end
        // a new expiry takes precedence over a clearing read
        if (expire && ien) c_d.flag = 1'b1;
        else if (clr)      c_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign count = c_q.count;
    assign flag  = c_q.flag;
endmodule

// File: rtl/dtmr_top.sv
module dtmr_top
    import dtmr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] A_HI   = 8'h94,
    parameter logic [ADDR_W-1:0] A_LO   = 8'h95,
    parameter logic [ADDR_W-1:0] A_STAT = 8'h92
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              fast_tick,
    input  logic              slow_tick,
    input  logic              rate_fast,
    output logic              irq
);
    logic             tick, start, clr, ien, flag;
    logic [CNT_W-1:0] load_val, count;

    dtmr_regfile #(.A_HI(A_HI), .A_LO(A_LO), .A_STAT(A_STAT)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .re(bus_re), .addr(bus_addr),
        .wdata(bus_wdata), .flag(flag), .rdata(bus_rdata), .load_val(load_val),
        .start(start), .clr(clr), .ien(ien)
    );

    dtmr_tick_sel u_sel (
        .fast_tick(fast_tick), .slow_tick(slow_tick), .rate_fast(rate_fast), .tick(tick)
    );

    dtmr_core u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .load_val(load_val),
        .ien(ien), .clr(clr), .count(count), .flag(flag)
    );

    assign irq = flag;
endmodule

// File: rtl/dtmr_checker.sv
module dtmr_checker
    import dtmr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             start,
    input logic             clr,
    input logic             ien,
    input logic [CNT_W-1:0] load_val,
    input logic [CNT_W-1:0] count,
    input logic             irq
);
    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> count == $past(load_val));

    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !start && count > CNT_W'(1)) |=> count == $past(count) - CNT_W'(1));

    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !start && count == CNT_W'(1)) |=> count == $past(load_val));

    p_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !start) |=> count == '0);

    p_need_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !(tick && !start && count == CNT_W'(1) && ien)) |=> !irq);

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(tick && !start && count == CNT_W'(1))) |=> !irq);

    p_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && tick && !start && count == CNT_W'(1) && ien) |=> irq);
endmodule

bind dtmr_top dtmr_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .clr(clr),
    .ien(ien), .load_val(load_val), .count(count), .irq(irq)
);

// File: tb/tb_dtmr_top.sv
module tb_dtmr_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0, bus_re = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       fast_tick = 1'b0, slow_tick = 1'b0, rate_fast = 1'b1;
    logic       irq;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    dtmr_top dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fast_tick(fast_tick), .slow_tick(slow_tick), .rate_fast(rate_fast), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd_stat(output logic [7:0] v);
        @(negedge clk); bus_re = 1'b1; bus_addr = 8'h92; #1 v = bus_rdata;
        @(negedge clk); bus_re = 1'b0;
    endtask

    task automatic ticks(input int n, input bit fast);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (fast) fast_tick = 1'b1; else slow_tick = 1'b1;
            @(negedge clk);
            fast_tick = 1'b0; slow_tick = 1'b0;
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 irq after reset", irq, 0);
        ticks(5, 1); ticks(5, 0);
        chk("R1 no irq while stopped", irq, 0);
        rd_stat(v);
        chk("R1 status after reset", v, 8'h00);
    endtask

    task automatic t_basic();
        logic [7:0] v;
        rate_fast = 1'b1;
        wr(8'h92, 8'h20);
        wr(8'h94, 8'h00); wr(8'h95, 8'h03);
        ticks(2, 1);
        chk("R5 no irq one tick early", irq, 0);
        ticks(1, 1);
        chk("R7 irq on third tick", irq, 1);
        rd_stat(v);
        chk("R9 status value", v, 8'h20);
        chk("R9 irq cleared by read", irq, 0);
        ticks(2, 1);
        chk("R6 reload, not yet", irq, 0);
        ticks(1, 1);
        chk("R6 second period fires", irq, 1);
        rd_stat(v);
    endtask

    task automatic t_rate();
        logic [7:0] v;
        rate_fast = 1'b0;
        wr(8'h95, 8'h02);
        ticks(5, 1);
        chk("R4 fast strobe ignored on slow rate", irq, 0);
        ticks(2, 0);
        chk("R4 slow strobe counts", irq, 1);
        rd_stat(v);
        rate_fast = 1'b1;
        wr(8'h95, 8'h02);
        ticks(4, 0);
        chk("R4 slow strobe ignored on fast rate", irq, 0);
        ticks(2, 1);
        chk("R4 fast strobe counts", irq, 1);
        rd_stat(v);
    endtask

    task automatic t_hibyte();
        logic [7:0] v;
        wr(8'h94, 8'h00); wr(8'h95, 8'h04);
        ticks(2, 1);
        wr(8'hF0 & 8'h94 | 8'h94, 8'hF1);
        ticks(1, 1);
        chk("R2 high write does not restart", irq, 0);
        ticks(1, 1);
        chk("R2 count kept through high write", irq, 1);
        rd_stat(v);
        ticks(259, 1);
        chk("R2 reload 0x104 not early", irq, 0);
        ticks(1, 1);
        chk("R2 reload 0x104 with upper bits masked", irq, 1);
        rd_stat(v);
        wr(8'h94, 8'h0F); wr(8'h95, 8'hFF);
        ticks(4094, 1);
        chk("R3 max load not early", irq, 0);
        ticks(1, 1);
        chk("R3 max load 4095 fires", irq, 1);
        rd_stat(v);
    endtask

    task automatic t_disabled();
        logic [7:0] v;
        wr(8'h92, 8'h00);
        wr(8'h94, 8'h00); wr(8'h95, 8'h02);
        ticks(4, 1);
        chk("R7 no irq when disabled", irq, 0);
        rd_stat(v);
        chk("R7 no pending flag when disabled", v, 8'h00);
        wr(8'h92, 8'h20);
    endtask

    task automatic t_zero();
        wr(8'h94, 8'h00); wr(8'h95, 8'h00);
        ticks(20, 1);
        rate_fast = 1'b0; ticks(20, 0); rate_fast = 1'b1;
        chk("R8 zero load stays stopped", irq, 0);
    endtask

    task automatic t_race();
        logic [7:0] v;
        wr(8'h95, 8'h01);
        ticks(1, 1);
        chk("R10 setup irq", irq, 1);
        @(negedge clk); bus_re = 1'b1; bus_addr = 8'h92; fast_tick = 1'b1; #1 v = bus_rdata;
        @(negedge clk); bus_re = 1'b0; fast_tick = 1'b0;
        chk("R10 read value during expiry", v, 8'h20);
        chk("R10 expiry wins over clear", irq, 1);
        rd_stat(v);
        chk("R9 plain read clears", irq, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_rate();
        t_hibyte();
        t_disabled();
        t_zero();
        t_race();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule